// File: doc/BRIEF.md
# Stepped Decibel Digital Gain Stage

This block scales a stereo stream of 24-bit signed audio samples by a programmable gain. The gain is set in half-decibel steps. It is the last stage of a decimating converter chain and sits after the DC-removal filters. Each beat carries one left and one right sample together, qualified by a valid strobe, at one beat per output sample period. The scaled pair leaves the block on a matching valid-qualified output two clock cycles later.

The gain is given as an 8-bit two's-complement code in half-decibel units. Codes run from -127 (-63.5 dB) to +48 (+24 dB). The block splits the code into a whole number of octaves, where one octave is 12 steps (about 6.02 dB), and a remainder of 0 to 11 steps. The remainder selects a mantissa equal to 2^(k/12). The octave count becomes an arithmetic shift. The block forms the product, rounds it once to the nearest integer, and clamps it to the signed 24-bit range. It raises a flag on any output pair in which a sample was clamped.

Top module: `dg_stepped_gain`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_clip, out_left and out_right are all zero after that edge.
- R2: out_valid is high exactly two clock cycles after in_valid was high, and low otherwise.
- R3: The gain code is 8-bit two's complement. A code below -127 acts as -127, and a code above +48 acts as +48.
- R4: For a clamped code c, let q = floor(c/12) and k = c - 12q, with k in 0..11. The gain is 2^q * M[k] / 32768, where M[k] = round(32768 * 2^(k/12)).
- R5: With s = 15 - q, each output sample is floor((x * M[k] + 2^(s-1)) / 2^s), which rounds to nearest with ties going upward.
- R6: Results above 8388607 or below -8388608 are clamped to those limits. out_clip is high for an output pair when either channel was clamped and low otherwise. A negative code never clips.
- R7: The gain code is sampled in the same cycle as in_valid, and both channels of that pair use it. Changes of the code while in_valid is low have no effect on the outputs.
- R8: While out_valid is low, out_left, out_right and out_clip keep their previous values.
- R9: Code 0 reproduces each input sample exactly.
- R10: Code +48 multiplies by exactly 16. Code -127 is the smallest gain, about -63.5 dB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pair strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| gain_code | input | 8 | Signed gain in half-dB units |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 24 | Left scaled sample, signed |
| out_right | output | 24 | Right scaled sample, signed |
| out_clip | output | 1 | Either channel of this pair was clamped |

## Verification
A sweep over all 256 code values with a fixed large sample pair tests every mantissa entry, every shift, the clamping of out-of-range codes and the onset of saturation. Opposite-sign samples on the two channels separate upward from downward rounding and positive from negative clipping. Back-to-back beats that alternate the code, and idle gaps in which the code and the data wander, separate per-beat gain capture from stale or leaking settings and test output holding. Random samples at random legal codes cover the remaining rounding cases, and unity gain with small and extreme values confirms that code 0 is exact.

// File: rtl/dg_pkg.sv
// Package: shared constants and the mantissa lookup for the stepped gain stage.
// Assumes 12 gain steps per octave and mantissas with 15 fractional bits.
package dg_pkg;
    localparam int STEPS     = 12;  // half-dB steps per octave
    localparam int MANT_FRAC = 15;  // fractional bits of a mantissa
    localparam int MANT_W    = 16;  // unsigned mantissa width

    typedef logic [MANT_W-1:0] mant_t;

    // Mantissa for remainder k: round(2^15 * 2^(k/12)).
    function automatic mant_t mant_of(input int k);
        case (k)
            0:       return mant_t'(32768);
            1:       return mant_t'(34716);
            2:       return mant_t'(36781);
            3:       return mant_t'(38968);
            4:       return mant_t'(41285);
            5:       return mant_t'(43740);
            6:       return mant_t'(46341);
            7:       return mant_t'(49097);
            8:       return mant_t'(52016);
            9:       return mant_t'(55109);
            10:      return mant_t'(58386);
            default: return mant_t'(61858);
        endcase
    endfunction
endpackage

// File: rtl/dg_gain_decode.sv
// Gain decoder: clamps a signed half-dB code to [CODE_MIN, CODE_MAX] and splits it
// into a mantissa (remainder within an octave) and a right-shift amount.
// Purely combinational. Assumes CODE_MIN is negative and CODE_MAX is non-negative.
module dg_gain_decode
    import dg_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int CODE_MIN = -127,
    parameter int CODE_MAX = 48,
    parameter int SH_W     = 5
) (
    input  logic signed [CODE_W-1:0] code,
    output mant_t                    mant,
    output logic [SH_W-1:0]          shamt
);
    localparam int QBIAS = (-CODE_MIN + STEPS - 1) / STEPS;  // octaves added to make the code non-negative
    localparam int UW    = CODE_W + 2;

    logic signed [CODE_W-1:0] code_c;
    logic [UW-1:0]            biased;
    logic [UW-1:0]            octave;
    logic [UW-1:0]            remain;

    // Clamp the code to the legal range.
    always_comb begin
        if (code < CODE_MIN)      code_c = CODE_W'(CODE_MIN);
        else if (code > CODE_MAX) code_c = CODE_W'(CODE_MAX);
        else                      code_c = code;
    end

    // Split the biased code into an octave count and a remainder, then map both.
    always_comb begin
        biased = UW'(int'(code_c) + STEPS * QBIAS);
        octave = biased / UW'(STEPS);
        remain = biased % UW'(STEPS);
        mant   = mant_of(int'(remain));
        shamt  = SH_W'(MANT_FRAC + QBIAS - int'(octave));
    end
endmodule

// File: rtl/dg_scale_lane.sv
// One channel of the scaler: multiplies a signed sample by an unsigned mantissa,
// rounds once at the shift point, saturates to DATA_W bits and registers the result.
// Assumes shamt is at least 1. Loads only when ld is high.
module dg_scale_lane #(
    parameter int DATA_W = 24,
    parameter int MANT_W = 16,
    parameter int SH_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld,
    input  logic signed [DATA_W-1:0] x,
    input  logic [MANT_W-1:0]        mant,
    input  logic [SH_W-1:0]          shamt,
    output logic signed [DATA_W-1:0] y,
    output logic                     clip
);
    localparam int PW = DATA_W + MANT_W + 2;
    localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [PW-1:0]     prod, rnd, shifted;
    logic signed [DATA_W-1:0] y_d;
    logic                     clip_d;

    // Multiply, add half an LSB of the result, shift down, then saturate.
    always_comb begin
        prod    = PW'(x) * PW'($signed({1'b0, mant}));
        rnd     = prod + (PW'(1) <<< (shamt - SH_W'(1)));
        shifted = rnd >>> shamt;
        if (shifted > MAXV) begin
            y_d = MAXV[DATA_W-1:0]; clip_d = 1'b1;
        end else if (shifted < MINV) begin
            y_d = MINV[DATA_W-1:0]; clip_d = 1'b1;
        end else begin
            y_d = shifted[DATA_W-1:0]; clip_d = 1'b0;
        end
    end

    // Output register, updated only for a valid beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y    <= '0;
            clip <= 1'b0;
        end else if (ld) begin
            y    <= y_d;
            clip <= clip_d;
        end
    end
endmodule

// File: rtl/dg_stepped_gain.sv
// Top: stereo half-dB stepped gain. Stage 1 captures the sample pair together with the
// decoded gain of the same beat. Stage 2 (one lane per channel) scales and saturates.
// Latency is two cycles. Assumes one stereo pair per valid beat.
module dg_stepped_gain
    import dg_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int CODE_W   = 8,
    parameter int CODE_MIN = -127,
    parameter int CODE_MAX = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic signed [CODE_W-1:0] gain_code,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right,
    output logic                     out_clip
);
    localparam int NCH  = 2;
    localparam int SH_W = 5;

    mant_t                    dec_mant, s1_mant;
    logic [SH_W-1:0]          dec_sh, s1_sh;
    logic                     s1_valid;
    logic signed [DATA_W-1:0] s1_x   [NCH];
    logic signed [DATA_W-1:0] lane_y [NCH];
    logic [NCH-1:0]           lane_clip;

    dg_gain_decode #(
        .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .SH_W(SH_W)
    ) u_dec (
        .code(gain_code), .mant(dec_mant), .shamt(dec_sh)
    );

    // Stage 1: capture the pair and its gain together so both channels share one setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mant  <= '0;
            s1_sh    <= '0;
            s1_x[0]  <= '0;
            s1_x[1]  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mant <= dec_mant;
                s1_sh   <= dec_sh;
                s1_x[0] <= in_left;
                s1_x[1] <= in_right;
            end
        end
    end

    // Stage 2: one scaling lane per channel.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        dg_scale_lane #(.DATA_W(DATA_W), .MANT_W(MANT_W), .SH_W(SH_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .ld(s1_valid),
            .x(s1_x[ch]), .mant(s1_mant), .shamt(s1_sh),
            .y(lane_y[ch]), .clip(lane_clip[ch])
        );
    end

    // Output strobe, aligned with the lane registers.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_valid;
    end

    assign out_left  = lane_y[0];
    assign out_right = lane_y[1];
    assign out_clip  = |lane_clip;
endmodule

// File: rtl/dg_stepped_gain_chk.sv
// Checker for dg_stepped_gain: temporal properties on the ports, bound to the top.
// Keeps a saturating count of cycles since reset so that $past never reaches before it.
module dg_stepped_gain_chk #(
    parameter int DATA_W = 24,
    parameter int CODE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_left,
    input logic signed [DATA_W-1:0] in_right,
    input logic signed [CODE_W-1:0] gain_code,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_left,
    input logic signed [DATA_W-1:0] out_right,
    input logic                     out_clip
);
    localparam logic signed [DATA_W-1:0] TOP = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] BOT = {1'b1, {(DATA_W-1){1'b0}}};

    logic [1:0] since_rst;

    // Count clock edges since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid) |->
            ($stable(out_left) && $stable(out_right) && $stable(out_clip)));

    p_clip_rail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_clip |-> (out_left == TOP || out_left == BOT || out_right == TOP || out_right == BOT));

    p_cut_no_clip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && $past(in_valid, 2) && $signed($past(gain_code, 2)) < 0) |-> !out_clip);

    p_unity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && $past(in_valid, 2) && $past(gain_code, 2) == '0) |->
            (out_left == $past(in_left, 2) && out_right == $past(in_right, 2) && !out_clip));
endmodule

bind dg_stepped_gain dg_stepped_gain_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .gain_code(gain_code), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right), .out_clip(out_clip)
);

// File: tb/tb_dg_stepped_gain.sv
// Scoreboard bench: the driver pushes expected pairs computed from the requirements,
// and the monitor pops and compares them whenever out_valid is seen.
module tb_dg_stepped_gain;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_left = '0, in_right = '0;
    logic signed [7:0]  gain_code = '0;
    logic               out_valid, out_clip;
    logic signed [23:0] out_left, out_right;

    typedef struct { int l; int r; bit c; string req; } exp_t;
    exp_t exp_q[$];

    int checks = 0, fails = 0;
    bit seen = 1'b0;
    int last_l = 0, last_r = 0;
    bit last_c = 1'b0;

    always #4 clk = ~clk;

    dg_stepped_gain dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .gain_code(gain_code), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right), .out_clip(out_clip)
    );

    // Reference per R3, R4, R5, R6.
    function automatic void model(input int x, input int code, output int y, output bit c);
        int cc, q, k, m, s;
        longint p, r;
        cc = (code < -127) ? -127 : (code > 48) ? 48 : code;
        q  = (cc >= 0) ? cc / 12 : -((-cc + 11) / 12);
        k  = cc - 12 * q;
        m  = int'($floor((2.0 ** (k / 12.0)) * 32768.0 + 0.5));
        s  = 15 - q;
        p  = longint'(x) * longint'(m);
        r  = (p + (longint'(1) <<< (s - 1))) >>> s;
        c  = 1'b0;
        if (r > 64'sd8388607)       begin r = 8388607;  c = 1'b1; end
        else if (r < -64'sd8388608) begin r = -8388608; c = 1'b1; end
        y = int'(r);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic send(input int l, input int r, input int code, input string req);
        exp_t e;
        bit cl, cr;
        model(l, code, e.l, cl);
        model(r, code, e.r, cr);
        e.c = cl | cr;
        e.req = req;
        @(negedge clk);
        in_valid  = 1'b1;
        in_left   = 24'(l);
        in_right  = 24'(r);
        gain_code = 8'(code);
        exp_q.push_back(e);
    endtask

    // Idle cycles with wandering data and code (R7: must have no effect).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_left   = 24'($urandom);
            in_right  = 24'($urandom);
            gain_code = 8'($urandom);
        end
    endtask

    // Monitor: compare valid beats against the queue; check holding otherwise (R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(out_left) == e.l, e.req, "left", int'(out_left), e.l);
                    check(int'(out_right) == e.r, e.req, "right", int'(out_right), e.r);
                    check(out_clip == e.c, e.req, "clip", int'(out_clip), int'(e.c));
                end
                seen = 1'b1;
                last_l = int'(out_left); last_r = int'(out_right); last_c = out_clip;
            end else if (seen) begin
                check(int'(out_left) == last_l && int'(out_right) == last_r && out_clip == last_c,
                      "R8", "hold left", int'(out_left), last_l);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, with inputs active during reset.
        in_valid = 1'b1; in_left = 24'sd1000; in_right = -24'sd1000; gain_code = 8'sd24;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !out_clip && out_left == 0 && out_right == 0,
              "R1", "reset outputs", int'(out_left), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2: single beat, then output must appear exactly two cycles later.
        send(100, -100, 0, "R2");
        @(negedge clk); in_valid = 1'b0;
        check(!out_valid, "R2", "valid after 1 cycle", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid, "R2", "valid after 2 cycles", int'(out_valid), 1);
        idle(3);

        // R9: unity gain, small and extreme values.
        send(0, 1, 0, "R9");
        send(-1, 8388607, 0, "R9");
        send(-8388608, 4660, 0, "R9");
        idle(2);

        // R10: extremes of the legal range.
        send(8191, -8192, 48, "R10");
        send(524288, -524289, 48, "R10");
        send(8388607, -8388608, -127, "R10");
        send(1000000, -1000000, -127, "R10");

        // R3, R4, R6: sweep all 256 codes with a large pair of opposite sign.
        for (int c = -128; c < 128; c++) send(3000001, -2999999, c, "R4");
        idle(3);

        // R3: out-of-range codes clamp to the limits.
        send(600000, -600000, 127, "R3");
        send(600000, -600000, -128, "R3");
        send(600000, -600000, 49, "R3");

        // R6: saturation on one channel only, both signs.
        send(8388607, 5, 12, "R6");
        send(-3, -8388608, 12, "R6");
        send(4194304, -4194304, 12, "R6");
        send(4194304, -4194305, 12, "R6");

        // R7: gain changes beat by beat and during gaps.
        send(77777, -77777, 0, "R7");
        send(77777, -77777, -12, "R7");
        idle(1);
        send(77777, -77777, 24, "R7");
        idle(4);
        send(77777, -77777, -60, "R7");
        send(77777, -77777, 5, "R7");

        // R5: rounding with random samples at random legal codes.
        for (int i = 0; i < 400; i++) begin
            send(int'($urandom) >>> 8, int'($urandom) >>> 8,
                 int'($urandom_range(175)) - 127, "R5");
            if (i % 37 == 0) idle(2);
        end
        // R5: exact ties at -6 dB (half LSB rounds up).
        send(1, -1, -12, "R5");
        send(3, -3, -12, "R5");

        idle(6);
        check(exp_q.size() == 0, "R2", "items left in scoreboard", exp_q.size(), 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule